// File: doc/BRIEF.md
# Memory and Stack Fault Classifier

This block turns one fault event of a microcoded processor into exactly one dispatch outcome. A pulse on the classify strobe samples five groups of inputs: a fault-status word with a fault-count field and an emulator flag, a map-status word, the stack status byte, the store flag, and the faulting address and stack pointers. One cycle later the block raises a single-cycle valid pulse. It then holds a one-hot outcome until the next strobe.

The outcomes fall into two groups. The unrecoverable outcomes are multiple faults, a fault in a non-emulator task, a memory fault that is not a map fault, and a fault of unknown origin. The recoverable outcomes are stack error, page fault and write-protect fault, and for these the block also prepares the data that recovery software needs:
- a stack pointer that is always legal,
- a masked fault address,
- the emulator program counter,
- the data that was being stored.

A stack error is reported in preference to a map fault. This is because handling a page fault while the stack pointer is bad would itself trap.

Top module: `fault_classifier`

## Requirements
- R1: While reset is active and until the first strobe after it, `outcome_o` is the idle code (bit 0 set), `valid_o` is 0, and `fault_addr_o`, `stkp_fix_o`, `saved_pc_o` and `saved_data_o` are zero.
- R2: A `classify_i` pulse produces `valid_o`=1 in the following cycle only. `outcome_o` keeps its value in every cycle that does not follow a strobe.
- R3: If the count field (`fault_info_i[CNT_W-1:0]`) is all ones, no memory fault is present. The outcome is then stack error (bit 5) if `stk_status_i` bit 7 (overflow) or bit 6 (underflow) is set, and unknown fault (bit 4) otherwise.
- R4: If the count field is all zeros, the outcome is multiple faults (bit 1).
- R5: For any other count value, if the emulator flag `fault_info_i[CNT_W]` is 0, the outcome is non-emulator fault (bit 2).
- R6: For an emulator fault whose not-map flag `err_status_i[0]` is 1, the outcome is non-map memory fault (bit 3).
- R7: For an emulator map fault, if stack bit 7 or bit 6 is set, or if `stkp_cur_i` is greater than STK_LIMIT (default 14), the outcome is stack error (bit 5).
- R8: Any other emulator map fault is a write-protect fault (bit 7) only when the protect flag `err_status_i[1]`=1, the dirty flag `err_status_i[2]`=0 and `store_ref_i`=1. Every other such fault is a page fault (bit 6).
- R9: On a page or write-protect outcome, `fault_addr_o` becomes `{va_hi_i & 16'h0FFF, va_lo_i}`. On any other outcome it keeps its value.
- R10: On a stack-error outcome, `stkp_fix_o` becomes `stkp_start_i` if that value is at most STK_LIMIT, and STK_LIMIT otherwise. On any other outcome it keeps its value.
- R11: On a stack-error, page or write-protect outcome, `saved_pc_o` becomes `~emu_pc_n_i` and `saved_data_o` becomes `store_data_i`. On any other outcome both keep their values.
- R12: `outcome_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| classify_i | input | 1 | Start one classification |
| fault_info_i | input | CNT_W+1 | Count field (low bits) and emulator flag (top bit) |
| err_status_i | input | 3 | bit0 not-map, bit1 write-protect, bit2 dirty |
| stk_status_i | input | 8 | bit7 overflow, bit6 underflow |
| store_ref_i | input | 1 | Faulting reference was a store |
| va_hi_i | input | DATA_W | Fault address, high half |
| va_lo_i | input | DATA_W | Fault address, low half |
| stkp_cur_i | input | SP_W | Stack pointer now |
| stkp_start_i | input | SP_W | Stack pointer at instruction start |
| emu_pc_n_i | input | DATA_W | Emulator PC, complemented |
| store_data_i | input | DATA_W | Data being stored |
| valid_o | output | 1 | Result pulse |
| outcome_o | output | 8 | One-hot outcome |
| fault_addr_o | output | 2*DATA_W | Masked fault address |
| stkp_fix_o | output | SP_W | Recovered stack pointer |
| saved_pc_o | output | DATA_W | Captured emulator PC |
| saved_data_o | output | DATA_W | Captured store data |

## Verification
The assertions check the following on every cycle:
- the outcome is always one-hot,
- the valid pulse follows a strobe and is one cycle long,
- the outcome holds between strobes,
- the recovered stack pointer is within the limit,
- the masked address bits stay zero,
- a zero count field gives the multiple-faults outcome.

The rest can only be shown by the bench's scenarios, because each depends on combinations of inputs:
- the full priority chain: count field, then emulator flag, then not-map flag, then stack condition, then protect/dirty/store,
- the limit boundary at 14 versus 15,
- whether the captured registers are left alone on unrecoverable outcomes.

// File: rtl/fault_classifier_pkg.sv
package fault_classifier_pkg;
  localparam int OC_N       = 8;
  localparam int OC_IDLE    = 0;
  localparam int OC_MANY    = 1;
  localparam int OC_NOT_EMU = 2;
  localparam int OC_NOT_MAP = 3;
  localparam int OC_UNKNOWN = 4;
  localparam int OC_STACK   = 5;
  localparam int OC_PAGE    = 6;
  localparam int OC_WPROT   = 7;
  localparam int STK_OVF_BIT = 7;
  localparam int STK_UNF_BIT = 6;
  typedef logic [OC_N-1:0] outcome_t;
endpackage

// File: rtl/fault_decode.sv
module fault_decode
  import fault_classifier_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SP_W      = 4,
  parameter int STK_LIMIT = 14
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             emu_i,
  input  logic             not_map_i,
  input  logic             wprot_i,
  input  logic             dirty_i,
  input  logic             store_i,
  input  logic [7:0]       stk_status_i,
  input  logic [SP_W-1:0]  stkp_cur_i,
  output outcome_t         oc_o
);
  localparam logic [SP_W-1:0] LIMIT = SP_W'(STK_LIMIT);

  logic cnt_ones, cnt_zero, stk_flag, sp_oob, is_wp;

  always_comb begin
    cnt_ones = &cnt_i;
    cnt_zero = ~|cnt_i;
    stk_flag = stk_status_i[STK_OVF_BIT] | stk_status_i[STK_UNF_BIT];
    sp_oob   = stkp_cur_i > LIMIT;
    is_wp    = wprot_i & ~dirty_i & store_i;
    oc_o     = '0;
    if (cnt_ones) begin
      if (stk_flag) oc_o[OC_STACK]   = 1'b1;
      else          oc_o[OC_UNKNOWN] = 1'b1;
    end else if (cnt_zero) begin
      oc_o[OC_MANY] = 1'b1;
    end else if (!emu_i) begin
      oc_o[OC_NOT_EMU] = 1'b1;
    end else if (not_map_i) begin
      oc_o[OC_NOT_MAP] = 1'b1;
    end else if (stk_flag || sp_oob) begin
      oc_o[OC_STACK] = 1'b1;
    end else if (is_wp) begin
      oc_o[OC_WPROT] = 1'b1;
    end else begin
      oc_o[OC_PAGE] = 1'b1;
    end
  end
endmodule

// File: rtl/stkp_recover.sv
module stkp_recover #(
  parameter int SP_W      = 4,
  parameter int STK_LIMIT = 14
) (
  input  logic [SP_W-1:0] start_i,
  output logic [SP_W-1:0] fix_o
);
  localparam logic [SP_W-1:0] LIMIT = SP_W'(STK_LIMIT);

  always_comb begin
    if (start_i > LIMIT) fix_o = LIMIT;
    else                 fix_o = start_i;
  end
endmodule

// File: rtl/fault_hold.sv
module fault_hold
  import fault_classifier_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SP_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  outcome_t            oc_i,
  input  logic [2*DATA_W-1:0] addr_i,
  input  logic [SP_W-1:0]     stkp_i,
  input  logic [DATA_W-1:0]   pc_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                valid_o,
  output outcome_t            oc_o,
  output logic [2*DATA_W-1:0] addr_o,
  output logic [SP_W-1:0]     stkp_o,
  output logic [DATA_W-1:0]   pc_o,
  output logic [DATA_W-1:0]   data_o
);
  logic en_oc, en_addr, en_stkp, en_cap;
  logic recoverable;

  always_comb begin
    recoverable = oc_i[OC_STACK] | oc_i[OC_PAGE] | oc_i[OC_WPROT];
    en_oc   = strobe_i;
    en_addr = strobe_i & (oc_i[OC_PAGE] | oc_i[OC_WPROT]);
    en_stkp = strobe_i & oc_i[OC_STACK];
    en_cap  = strobe_i & recoverable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      oc_o    <= outcome_t'(1) << OC_IDLE;
      addr_o  <= '0;
      stkp_o  <= '0;
      pc_o    <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= strobe_i;
      if (en_oc)   oc_o   <= oc_i;
      if (en_addr) addr_o <= addr_i;
      if (en_stkp) stkp_o <= stkp_i;
      if (en_cap) begin
        pc_o   <= pc_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier
  import fault_classifier_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SP_W      = 4,
  parameter int STK_LIMIT = 14,
  parameter int HI_KEEP   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                classify_i,
  input  logic [CNT_W:0]      fault_info_i,
  input  logic [2:0]          err_status_i,
  input  logic [7:0]          stk_status_i,
  input  logic                store_ref_i,
  input  logic [DATA_W-1:0]   va_hi_i,
  input  logic [DATA_W-1:0]   va_lo_i,
  input  logic [SP_W-1:0]     stkp_cur_i,
  input  logic [SP_W-1:0]     stkp_start_i,
  input  logic [DATA_W-1:0]   emu_pc_n_i,
  input  logic [DATA_W-1:0]   store_data_i,
  output logic                valid_o,
  output logic [7:0]          outcome_o,
  output logic [2*DATA_W-1:0] fault_addr_o,
  output logic [SP_W-1:0]     stkp_fix_o,
  output logic [DATA_W-1:0]   saved_pc_o,
  output logic [DATA_W-1:0]   saved_data_o
);
  localparam logic [DATA_W-1:0] HI_MASK = {{(DATA_W-HI_KEEP){1'b0}}, {HI_KEEP{1'b1}}};

  logic [1:0]          rst_sync;
  logic                rst_core_n;
  outcome_t            oc_next;
  outcome_t            oc_q;
  logic [SP_W-1:0]     stkp_next;
  logic [2*DATA_W-1:0] addr_next;
  logic [DATA_W-1:0]   pc_next;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  always_comb begin
    addr_next = {va_hi_i & HI_MASK, va_lo_i};
    pc_next   = ~emu_pc_n_i;
  end

  fault_decode #(
    .CNT_W(CNT_W), .SP_W(SP_W), .STK_LIMIT(STK_LIMIT)
  ) u_decode (
    .cnt_i       (fault_info_i[CNT_W-1:0]),
    .emu_i       (fault_info_i[CNT_W]),
    .not_map_i   (err_status_i[0]),
    .wprot_i     (err_status_i[1]),
    .dirty_i     (err_status_i[2]),
    .store_i     (store_ref_i),
    .stk_status_i(stk_status_i),
    .stkp_cur_i  (stkp_cur_i),
    .oc_o        (oc_next)
  );

  stkp_recover #(
    .SP_W(SP_W), .STK_LIMIT(STK_LIMIT)
  ) u_recover (
    .start_i(stkp_start_i),
    .fix_o  (stkp_next)
  );

  fault_hold #(
    .DATA_W(DATA_W), .SP_W(SP_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .strobe_i(classify_i),
    .oc_i    (oc_next),
    .addr_i  (addr_next),
    .stkp_i  (stkp_next),
    .pc_i    (pc_next),
    .data_i  (store_data_i),
    .valid_o (valid_o),
    .oc_o    (oc_q),
    .addr_o  (fault_addr_o),
    .stkp_o  (stkp_fix_o),
    .pc_o    (saved_pc_o),
    .data_o  (saved_data_o)
  );

  assign outcome_o = oc_q;
endmodule

// File: rtl/fault_classifier_chk.sv
module fault_classifier_chk #(
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 16,
  parameter int SP_W      = 4,
  parameter int STK_LIMIT = 14,
  parameter int HI_KEEP   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                classify_i,
  input logic [CNT_W:0]      fault_info_i,
  input logic                valid_o,
  input logic [7:0]          outcome_o,
  input logic [2*DATA_W-1:0] fault_addr_o,
  input logic [SP_W-1:0]     stkp_fix_o
);
  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(outcome_o) == 1);

  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    classify_i |=> valid_o);

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !classify_i |=> !valid_o);

  p_hold_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !classify_i |=> $stable(outcome_o));

  p_many_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (classify_i && fault_info_i[CNT_W-1:0] == '0) |=> outcome_o[1]);

  p_stkp_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stkp_fix_o <= SP_W'(STK_LIMIT));

  p_addr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr_o[2*DATA_W-1 -: (DATA_W-HI_KEEP)] == '0);
endmodule

bind fault_classifier fault_classifier_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .SP_W(SP_W),
  .STK_LIMIT(STK_LIMIT), .HI_KEEP(HI_KEEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .classify_i(classify_i),
  .fault_info_i(fault_info_i), .valid_o(valid_o), .outcome_o(outcome_o),
  .fault_addr_o(fault_addr_o), .stkp_fix_o(stkp_fix_o)
);

// File: tb/fault_classifier_test.sv
`timescale 1ns/1ps
module fault_classifier_test;
  localparam int CNT_W = 4, DATA_W = 16, SP_W = 4, LIMIT = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic classify_i;
  logic [CNT_W:0] fault_info_i;
  logic [2:0] err_status_i;
  logic [7:0] stk_status_i;
  logic store_ref_i;
  logic [DATA_W-1:0] va_hi_i, va_lo_i, emu_pc_n_i, store_data_i;
  logic [SP_W-1:0] stkp_cur_i, stkp_start_i;
  logic valid_o;
  logic [7:0] outcome_o;
  logic [2*DATA_W-1:0] fault_addr_o;
  logic [SP_W-1:0] stkp_fix_o;
  logic [DATA_W-1:0] saved_pc_o, saved_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [7:0] m_oc;
  logic [2*DATA_W-1:0] m_addr;
  logic [SP_W-1:0] m_stkp;
  logic [DATA_W-1:0] m_pc, m_data;

  always #2.5 clk = ~clk;

  fault_classifier uut (
    .clk(clk), .rst_n(rst_n), .classify_i(classify_i),
    .fault_info_i(fault_info_i), .err_status_i(err_status_i),
    .stk_status_i(stk_status_i), .store_ref_i(store_ref_i),
    .va_hi_i(va_hi_i), .va_lo_i(va_lo_i), .stkp_cur_i(stkp_cur_i),
    .stkp_start_i(stkp_start_i), .emu_pc_n_i(emu_pc_n_i),
    .store_data_i(store_data_i), .valid_o(valid_o), .outcome_o(outcome_o),
    .fault_addr_o(fault_addr_o), .stkp_fix_o(stkp_fix_o),
    .saved_pc_o(saved_pc_o), .saved_data_o(saved_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_idx();
    logic [CNT_W-1:0] c;
    bit stk;
    c = fault_info_i[CNT_W-1:0];
    stk = stk_status_i[7] | stk_status_i[6];
    if (&c) return stk ? 5 : 4;
    if (c == 0) return 1;
    if (!fault_info_i[CNT_W]) return 2;
    if (err_status_i[0]) return 3;
    if (stk || stkp_cur_i > LIMIT) return 5;
    if (err_status_i[1] && !err_status_i[2] && store_ref_i) return 7;
    return 6;
  endfunction

  function automatic string tag_of(int i);
    case (i)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R3";
      5: return (&fault_info_i[CNT_W-1:0]) ? "R3" : "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [CNT_W:0] fi, input logic [2:0] es,
                       input logic [7:0] ss, input logic st,
                       input logic [SP_W-1:0] cur, input logic [SP_W-1:0] start,
                       input logic [DATA_W-1:0] hi);
    fault_info_i = fi; err_status_i = es; stk_status_i = ss; store_ref_i = st;
    stkp_cur_i = cur; stkp_start_i = start; va_hi_i = hi;
    va_lo_i = DATA_W'($urandom); emu_pc_n_i = DATA_W'($urandom);
    store_data_i = DATA_W'($urandom);
  endtask

  // inputs already driven; called just after a negedge
  task automatic run_one();
    int idx;
    string t;
    idx = exp_idx();
    t = tag_of(idx);
    m_oc = 8'(1) << idx;
    if (idx == 6 || idx == 7) m_addr = {va_hi_i & 16'h0FFF, va_lo_i};
    if (idx == 5) m_stkp = (stkp_start_i > LIMIT) ? SP_W'(LIMIT) : stkp_start_i;
    if (idx >= 5) begin m_pc = ~emu_pc_n_i; m_data = store_data_i; end
    classify_i = 1'b1;
    @(negedge clk);
    classify_i = 1'b0;
    chk(valid_o == 1'b1, "R2 valid pulse", 64'(valid_o), 1);
    chk(outcome_o == m_oc, t, 64'(outcome_o), 64'(m_oc));
    chk(fault_addr_o == m_addr, "R9 address", 64'(fault_addr_o), 64'(m_addr));
    chk(stkp_fix_o == m_stkp, "R10 stack pointer", 64'(stkp_fix_o), 64'(m_stkp));
    chk(saved_pc_o == m_pc, "R11 pc", 64'(saved_pc_o), 64'(m_pc));
    chk(saved_data_o == m_data, "R11 data", 64'(saved_data_o), 64'(m_data));
    // disturb inputs while idle: outcome must hold
    drive(fault_info_i ^ 5'h1F, ~err_status_i, ~stk_status_i, ~store_ref_i,
          ~stkp_cur_i, ~stkp_start_i, ~va_hi_i);
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 single pulse", 64'(valid_o), 0);
    chk(outcome_o == m_oc, "R2 hold", 64'(outcome_o), 64'(m_oc));
    chk($countones(outcome_o) == 1, "R12 one-hot", 64'(outcome_o), 64'(m_oc));
  endtask

  initial begin
    void'($urandom(32'd1983));
    rst_n = 1'b0; classify_i = 1'b0;
    drive('1, '0, '0, 1'b0, '0, '0, '0);
    m_oc = 8'h01; m_addr = '0; m_stkp = '0; m_pc = '0; m_data = '0;
    repeat (3) @(negedge clk);
    chk(outcome_o == 8'h01 && valid_o == 1'b0, "R1 reset outcome",
        64'(outcome_o), 1);
    chk(fault_addr_o == 0 && stkp_fix_o == 0 && saved_pc_o == 0 && saved_data_o == 0,
        "R1 reset registers", 64'(saved_pc_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(outcome_o == 8'h01 && valid_o == 1'b0, "R1 after release",
        64'(outcome_o), 1);

    // directed corners
    drive(5'h0F, 3'b000, 8'h80, 1'b0, 4'd3, 4'd2, 16'h1234); run_one(); // R3 overflow
    drive(5'h0F, 3'b000, 8'h40, 1'b0, 4'd3, 4'd15, 16'h1234); run_one(); // R3 underflow, clamp
    drive(5'h1F, 3'b000, 8'h3F, 1'b0, 4'd15, 4'd2, 16'h1234); run_one(); // R3 unknown
    drive(5'h10, 3'b000, 8'h00, 1'b0, 4'd0, 4'd0, 16'h0); run_one();      // R4
    drive(5'h05, 3'b000, 8'h00, 1'b0, 4'd0, 4'd0, 16'h0); run_one();      // R5
    drive(5'h15, 3'b001, 8'h80, 1'b1, 4'd0, 4'd0, 16'h0); run_one();      // R6 beats stack
    drive(5'h11, 3'b010, 8'h00, 1'b1, 4'd15, 4'd14, 16'hFFFF); run_one(); // R7 oob, R10 at limit
    drive(5'h11, 3'b010, 8'h00, 1'b1, 4'd14, 4'd1, 16'hFFFF); run_one();  // R8 wp at limit, R9 mask
    drive(5'h11, 3'b110, 8'h00, 1'b1, 4'd0, 4'd1, 16'hF00F); run_one();   // R8 dirty -> page
    drive(5'h11, 3'b010, 8'h00, 1'b0, 4'd0, 4'd1, 16'hABCD); run_one();   // R8 load -> page
    drive(5'h12, 3'b000, 8'h00, 1'b0, 4'd0, 4'd1, 16'h0F0F); run_one();   // R8 page

    // random
    for (int i = 0; i < 400; i++) begin
      logic [CNT_W:0] fi;
      int sel;
      sel = $urandom_range(0, 3);
      fi = (CNT_W+1)'($urandom);
      if (sel == 0) fi[CNT_W-1:0] = '1;
      else if (sel == 1) fi[CNT_W-1:0] = '0;
      else if (sel == 2) fi[CNT_W] = 1'b1;
      drive(fi, 3'($urandom), 8'($urandom), 1'($urandom), SP_W'($urandom),
            SP_W'($urandom), DATA_W'($urandom));
      if ($urandom_range(0, 1) == 1) stk_status_i[7:6] = 2'b00;
      run_one();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule